// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

An eight-pin general-purpose I/O port with a small register interface. Each pin can be an input or an output, can be given over to an alternate peripheral signal, and can request a pull resistor when it is an input. The pad side is a value, an output enable and pull controls for each pin. Analog pad behaviour and the peripheral functions themselves lie outside the block.

Every pin input passes through a two-flop synchronizer. A third flop holds the previous synchronized value, so each pin can detect a rising or a falling transition, chosen per pin. A detected transition latches into a sticky per-pin flag. One combined interrupt request is raised whenever any pin has both its flag and its enable bit set. Only software clears flags, and software may also set them to force a pending request.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every writable register holds 0, `pad_oe`, `pad_pull_en` and `irq` are 0. The register addresses are 0 input (read only), 1 output, 2 direction, 3 function select, 4 pull enable, 5 edge select, 6 interrupt enable and 7 flags. Bit n of each register belongs to pin n.
- R2: A direction bit of 1 sets `pad_oe[n]` and drives `pad_out[n]` from the output register. A direction bit of 0 clears `pad_oe[n]`.
- R3: Reading address 0 returns the pad inputs through a two-flop synchronizer. A change applied before clock edge k is visible in the read data after edge k+1, and not after edge k alone.
- R4: With edge select bit 0, a low-to-high transition on a pin sets its flag. The flag is set at the third clock edge after the pad changes. A high-to-low transition does not set it.
- R5: With edge select bit 1, a high-to-low transition sets the flag. A low-to-high transition does not set it.
- R6: A flag stays set until software writes 0 to that bit at address 7. Writing 1 to a flag bit sets it. Writes to other registers never clear a flag.
- R7: `irq` is 1 exactly when some pin has both its flag bit and its enable bit set.
- R8: A function-select bit of 1 drives `pad_out[n]` from `alt_out[n]` instead of the output register. The direction bit still controls `pad_oe[n]`.
- R9: `pad_pull_en[n]` is 1 only when the pull-enable bit is set and the pin is an input. `pad_pull_up[n]` equals the output register bit (1 means pull-up, 0 means pull-down).
- R10: Changing an edge select bit while the pin input is steady does not set a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pad_in | input | 8 | Pin input values from the pads |
| pad_out | output | 8 | Pin output values to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pull_en | output | 8 | Per-pin pull resistor enable |
| pad_pull_up | output | 8 | Pull direction: 1 up, 0 down |
| alt_out | input | 8 | Alternate peripheral signal for each pin |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check that flags only fall through a flag-register write and only rise through a detected transition or a write. They also check that no pull resistor is enabled on a driven pin and that a request never appears without a pending flag. The edge polarity per pin, the synchronizer latency, the alternate-signal routing and the absence of a flag after an edge-select change can only be shown by the bench's scenarios, which drive pad sequences and read the registers back.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int PINS = 8,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_pull_en,
  output logic [PINS-1:0] pad_pull_up,
  input  logic [PINS-1:0] alt_out,
  output logic            irq
);
  localparam logic [AW-1:0] A_IN = 3'd0, A_OUT = 3'd1, A_DIR = 3'd2, A_SEL = 3'd3,
                            A_PULL = 3'd4, A_EDGE = 3'd5, A_IEN = 3'd6, A_FLAG = 3'd7;

  logic [PINS-1:0] out_r, dir_r, sel_r, pull_r, edge_r, ien_r, flag_r;
  logic [PINS-1:0] sync1, sync2, prev;
  logic [PINS-1:0] hit;
  logic            flag_wr;

  assign flag_wr = we && (addr == A_FLAG);
  assign hit = (edge_r & prev & ~sync2) | (~edge_r & ~prev & sync2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r  <= '0;
      dir_r  <= '0;
      sel_r  <= '0;
      pull_r <= '0;
      edge_r <= '0;
      ien_r  <= '0;
      flag_r <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_OUT:   out_r  <= wdata;
          A_DIR:   dir_r  <= wdata;
          A_SEL:   sel_r  <= wdata;
          A_PULL:  pull_r <= wdata;
          A_EDGE:  edge_r <= wdata;
          A_IEN:   ien_r  <= wdata;
          default: ;
        endcase
      end
      flag_r <= (flag_wr ? wdata : flag_r) | hit;
    end
  end

  always_comb begin
    case (addr)
      A_IN:    rdata = sync2;
      A_OUT:   rdata = out_r;
      A_DIR:   rdata = dir_r;
      A_SEL:   rdata = sel_r;
      A_PULL:  rdata = pull_r;
      A_EDGE:  rdata = edge_r;
      A_IEN:   rdata = ien_r;
      default: rdata = flag_r;
    endcase
  end

  assign pad_out     = (sel_r & alt_out) | (~sel_r & out_r);
  assign pad_oe      = dir_r;
  assign pad_pull_en = pull_r & ~dir_r;
  assign pad_pull_up = out_r;
  assign irq         = |(flag_r & ien_r);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_r & $past(flag_r)) == $past(flag_r)));  // R6
  AST_FLAG_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && (sync2 == prev)) |=> (flag_r == $past(flag_r)));  // R10
  AST_PULL_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_en & pad_oe) == '0);  // R9
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_r != '0));  // R7
endmodule

// File: tb/sim_gpio_edge_port.sv
module sim_gpio_edge_port;
  logic       clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, pad_in = 0, pad_out, pad_oe, pad_pull_en, pad_pull_up, alt_out = 0;
  logic       irq;
  int checks = 0, fails = 0;

  gpio_edge_port u0 (.clk, .rst_n, .we, .addr, .wdata, .rdata, .pad_in, .pad_out,
    .pad_oe, .pad_pull_en, .pad_pull_up, .alt_out, .irq);

  always #4 clk = ~clk;

  initial begin
    #1600000;
    fails++; checks++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pads(input logic [7:0] v, input int n);
    @(negedge clk); pad_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 1; a < 8; a++) begin rd(3'(a), d); chk("R1 reg", d, 8'h00); end
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 pull", pad_pull_en, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_dir;
    wr(1, 8'hA5); wr(2, 8'h0F);
    chk("R2 oe", pad_oe, 8'h0F);
    chk("R2 out", pad_out & pad_oe, 8'h05);
    wr(2, 8'h00);
    chk("R2 oe off", pad_oe, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] d;
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); rd(0, d); chk("R3 early", d, 8'h00);
    @(negedge clk); rd(0, d); chk("R3 late", d, 8'h3C);
    pads(8'h00, 4); wr(7, 8'h00);
  endtask

  task automatic t_rise;
    logic [7:0] d;
    wr(5, 8'h00); wr(7, 8'h00);
    @(negedge clk); pad_in = 8'h01;
    @(negedge clk); @(negedge clk); rd(7, d); chk("R4 not yet", d, 8'h00);
    @(negedge clk); rd(7, d); chk("R4 rise", d, 8'h01);
    wr(7, 8'h00); pads(8'h00, 4); rd(7, d); chk("R4 fall ignored", d, 8'h00);
  endtask

  task automatic t_fall;
    logic [7:0] d;
    wr(5, 8'h02); pads(8'h02, 4); rd(7, d); chk("R5 rise ignored", d & 8'h02, 8'h00);
    wr(7, 8'h00);
    pads(8'h00, 4); rd(7, d); chk("R5 fall", d, 8'h02);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    wr(1, 8'hFF); wr(6, 8'h00); pads(8'h00, 3);
    rd(7, d); chk("R6 sticky", d, 8'h02);
    wr(7, 8'h80); rd(7, d); chk("R6 set/clear", d, 8'h80);
    wr(7, 8'h00); rd(7, d); chk("R6 clear", d, 8'h00);
    wr(1, 8'h00);
  endtask

  task automatic t_irq;
    wr(7, 8'h10); wr(6, 8'h08);
    chk("R7 no match", {7'd0, irq}, 8'h00);
    wr(6, 8'h18); chk("R7 match", {7'd0, irq}, 8'h01);
    wr(7, 8'h00); chk("R7 cleared", {7'd0, irq}, 8'h00);
    wr(6, 8'h00);
  endtask

  task automatic t_alt;
    wr(1, 8'h00); wr(2, 8'hF0); wr(3, 8'h30);
    @(negedge clk); alt_out = 8'hFF; #1;
    chk("R8 alt", pad_out & pad_oe, 8'h30);
    chk("R8 oe", pad_oe, 8'hF0);
    wr(3, 8'h00); alt_out = 0; wr(2, 8'h00);
  endtask

  task automatic t_pull;
    wr(4, 8'hFF); wr(2, 8'h0F); wr(1, 8'hAA);
    chk("R9 en", pad_pull_en, 8'hF0);
    chk("R9 up", pad_pull_up, 8'hAA);
    wr(4, 8'h00); wr(2, 8'h00); wr(1, 8'h00);
  endtask

  task automatic t_edgesel;
    logic [7:0] d;
    wr(5, 8'h00); pads(8'hF0, 4); wr(7, 8'h00);
    wr(5, 8'hFF); repeat (3) @(negedge clk);
    rd(7, d); chk("R10 to fall", d, 8'h00);
    wr(5, 8'h00); repeat (3) @(negedge clk);
    rd(7, d); chk("R10 to rise", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_dir; t_sync; t_rise; t_fall; t_sticky; t_irq; t_alt; t_pull; t_edgesel;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule